// File: doc/BRIEF.md
# Wrapping Page Buffer with Self-Timed Commit

This block sits between a bus-side command sequencer and a byte-wide storage array. The sequencer hands it a start address and then a stream of single data bits. The block packs each group of eight bits into a byte and places that byte in a page-sized staging buffer. Consecutive bytes go to consecutive positions, and the position wraps around inside the page. A bit mask records which positions have been filled.

When the sequencer asks for a commit, the block checks two things: the write-enable latch must be set, and the write-protect input must be high. If both hold, the block starts a self-timed write that lasts a fixed number of clock cycles. This stands in for the nonvolatile programming time. During the first page-sized stretch of that window, the block walks the buffer and drives the array's write port for every filled position.

A status level reads 0 while the write runs and 1 otherwise. A one-cycle pulse tells the sequencer to clear its write-enable latch once the write finishes.

Top module: `pgw_page_writer`

## Requirements
- R1: A start-address load takes the page number from `start_addr[ADDR_W-1:PAGE_W]` and the byte position from `start_addr[PAGE_W-1:0]`, and it discards any bytes already staged. Each group of eight `bit_stb` pulses forms one byte, first bit most significant. The byte is staged at the current position, and the position then advances by one.
- R2: After the last position of the page (all low bits one), the position wraps to position 0 of the same page. Bytes loaded after the wrap replace earlier bytes at the same position.
- R3: An accepted commit writes each staged byte, and only staged bytes, to array address `{page, position}`. Anywhere from a single byte to a full page of 2**PAGE_W bytes is allowed. A trailing group of fewer than eight bits is dropped.
- R4: A commit request is refused while `wp_n` is low. Pulling `wp_n` low during an active commit does not shorten it or stop its writes.
- R5: `status` is 1 when idle. After an accepted request, `status` is 0 for exactly COMMIT_CYCLES cycles and then returns to 1.
- R6: `seq_reset` during an active commit has no effect. When the block is idle, `seq_reset` discards all staged bytes and any partial bits.
- R7: `wel_clr` pulses high for one cycle, in the first cycle that `status` is back at 1 after a commit.
- R8: A commit request is refused while `wel` is low.
- R9: Completing a commit empties the staged set. A request made while nothing is staged is refused.
- R10: Bit strobes and address loads that arrive during an active commit are ignored.
- R11: After reset, `status` is 1, `mem_we` is 0 and `wel_clr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | One data bit is presented on `bit_val` |
| bit_val | input | 1 | Serial data bit |
| addr_ld | input | 1 | Load `start_addr` and open a new page load |
| start_addr | input | ADDR_W | Start address of the page load |
| seq_reset | input | 1 | Reset request from the sequencer |
| commit_req | input | 1 | Request to start the self-timed write |
| wel | input | 1 | Write-enable latch state |
| wp_n | input | 1 | Write protect, low blocks new commits |
| status | output | 1 | 0 while a commit runs, 1 otherwise |
| wel_clr | output | 1 | One-cycle pulse at commit completion |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The assertions assume that each control strobe is a clean one-cycle pulse sampled on the clock. They also assume that the array accepts a write in every cycle `mem_we` is high. The checks on the commit window assume COMMIT_CYCLES is at least one page long, so that the buffer walk ends inside the busy window.

The stimulus drives every input half a cycle away from the active edge and raises only one strobe at a time, except where it deliberately tests that the block ignores input. The random part draws addresses across the whole array, and byte counts both below and above one page, so that wrap and overwrite occur. Protection and latch states are also drawn at random, and any refused load is flushed with an idle `seq_reset`.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pgw_loader.sv
module pgw_loader
   import pgw_pkg::*;
#(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned PAGE_W = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     busy,
   input  logic                     commit_done,
   input  logic                     bit_stb,
   input  logic                     bit_val,
   input  logic                     addr_ld,
   input  logic [ADDR_W-1:0]        start_addr,
   input  logic                     seq_reset,
   input  logic [PAGE_W-1:0]        rd_idx,
   output byte_t                    rd_byte,
   output logic                     rd_valid,
   output logic                     any_loaded,
   output logic [ADDR_W-PAGE_W-1:0] page_addr
);
   localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
   localparam int unsigned PG_W       = ADDR_W - PAGE_W;

   generate
      if (ADDR_W <= PAGE_W) begin : g_bad_addr
         $error("pgw_loader: ADDR_W must exceed PAGE_W");
      end
   endgenerate

   logic [2:0]            bit_cnt;
   logic [BYTE_W-2:0]     shreg;
   logic [PAGE_W-1:0]     ptr;
   logic [PG_W-1:0]       page_q;
   byte_t                 pbuf [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] mask;
   logic                  take, byte_done, flush;

   assign take      = !busy && !seq_reset && !addr_ld && bit_stb;
   assign byte_done = take && (bit_cnt == 3'd7);
   assign flush     = commit_done || (!busy && (seq_reset || addr_ld));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
         ptr     <= '0;
         page_q  <= '0;
      end else if (commit_done || (!busy && seq_reset)) begin
         bit_cnt <= '0;
      end else if (!busy && addr_ld) begin
         bit_cnt <= '0;
         page_q  <= start_addr[ADDR_W-1:PAGE_W];
         ptr     <= start_addr[PAGE_W-1:0];
      end else if (take) begin
         shreg   <= {shreg[BYTE_W-3:0], bit_val};
         bit_cnt <= bit_cnt + 3'd1;
         if (byte_done) ptr <= ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (byte_done) pbuf[ptr] <= {shreg, bit_val};
   end

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_vld
      logic vbit;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               vbit <= 1'b0;
         else if (flush)                           vbit <= 1'b0;
         else if (byte_done && ptr == PAGE_W'(g))  vbit <= 1'b1;
      end
      assign mask[g] = vbit;
   end

   assign rd_byte    = pbuf[rd_idx];
   assign rd_valid   = mask[rd_idx];
   assign any_loaded = |mask;
   assign page_addr  = page_q;

   // R2: position wraps to the first byte of the same page
   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && ptr == {PAGE_W{1'b1}}) |=> (ptr == '0));

   // R10: staged set frozen while a commit runs
   p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !commit_done) |=> $stable(mask));
endmodule

// File: rtl/pgw_commit.sv
module pgw_commit
   import pgw_pkg::*;
#(
   parameter int unsigned ADDR_W        = 15,
   parameter int unsigned PAGE_W        = 6,
   parameter int unsigned COMMIT_CYCLES = 200
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     commit_req,
   input  logic                     wel,
   input  logic                     wp_n,
   input  logic                     any_loaded,
   input  logic [ADDR_W-PAGE_W-1:0] page_addr,
   input  logic                     byte_valid,
   input  byte_t                    byte_data,
   output logic [PAGE_W-1:0]        rd_idx,
   output logic                     busy,
   output logic                     done,
   output logic                     wel_clr,
   output logic                     mem_we,
   output logic [ADDR_W-1:0]        mem_addr,
   output byte_t                    mem_wdata
);
   localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
   localparam int unsigned CNT_W      = $clog2(COMMIT_CYCLES) + 1;
   localparam logic [CNT_W-1:0] LAST     = CNT_W'(COMMIT_CYCLES - 1);
   localparam logic [CNT_W-1:0] PAGE_LIM = CNT_W'(PAGE_BYTES);

   generate
      if (COMMIT_CYCLES < PAGE_BYTES) begin : g_bad_len
         $error("pgw_commit: COMMIT_CYCLES must cover one page walk");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             busy_q, wel_clr_q, start, in_walk;

   assign start   = !busy_q && commit_req && wel && wp_n && any_loaded;
   assign done    = busy_q && (cnt == LAST);
   assign in_walk = cnt < PAGE_LIM;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         cnt       <= '0;
         wel_clr_q <= 1'b0;
      end else begin
         wel_clr_q <= done;
         if (start) begin
            busy_q <= 1'b1;
            cnt    <= '0;
         end else if (done) begin
            busy_q <= 1'b0;
         end else if (busy_q) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign busy      = busy_q;
   assign wel_clr   = wel_clr_q;
   assign rd_idx    = cnt[PAGE_W-1:0];
   assign mem_we    = busy_q && in_walk && byte_valid;
   assign mem_addr  = {page_addr, rd_idx};
   assign mem_wdata = byte_data;

   // R4: protection blocks a start
   p_start_wp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(wp_n));
   // R4: nothing ends a commit early
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt != LAST) |=> busy_q);
   // R8: latch must be set for a start
   p_start_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(wel));
   // R7: latch clear pulse at completion
   p_welclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> wel_clr_q);
   // R3: array writes only inside a commit
   p_we_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy_q);
endmodule

// File: rtl/pgw_page_writer.sv
module pgw_page_writer
   import pgw_pkg::*;
#(
   parameter int unsigned ADDR_W        = 15,
   parameter int unsigned PAGE_W        = 6,
   parameter int unsigned COMMIT_CYCLES = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic              addr_ld,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              seq_reset,
   input  logic              commit_req,
   input  logic              wel,
   input  logic              wp_n,
   output logic              status,
   output logic              wel_clr,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata
);
   localparam int unsigned PG_W = ADDR_W - PAGE_W;

   logic              busy, done, rd_valid, any_loaded;
   logic [PAGE_W-1:0] rd_idx;
   byte_t             rd_byte;
   logic [PG_W-1:0]   page_addr;

   pgw_loader #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_loader (
      .clk(clk), .rst_n(rst_n), .busy(busy), .commit_done(done),
      .bit_stb(bit_stb), .bit_val(bit_val), .addr_ld(addr_ld),
      .start_addr(start_addr), .seq_reset(seq_reset), .rd_idx(rd_idx),
      .rd_byte(rd_byte), .rd_valid(rd_valid), .any_loaded(any_loaded),
      .page_addr(page_addr)
   );

   pgw_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .COMMIT_CYCLES(COMMIT_CYCLES)) i_commit (
      .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .wel(wel),
      .wp_n(wp_n), .any_loaded(any_loaded), .page_addr(page_addr),
      .byte_valid(rd_valid), .byte_data(rd_byte), .rd_idx(rd_idx),
      .busy(busy), .done(done), .wel_clr(wel_clr), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   assign status = !busy;

   // R9: staged set empty once a commit ends
   p_mask_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !any_loaded);
   // R6: a sequencer reset cannot end a commit in progress
   p_reset_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && seq_reset) |=> busy);
endmodule

// File: tb/test_pgw_page_writer.sv
module test_pgw_page_writer;
   localparam int CLK_P = 10;
   localparam int AW    = 10;
   localparam int PW    = 6;
   localparam int CC    = 80;
   localparam int DEPTH = 1 << AW;
   localparam int PB    = 1 << PW;

   logic clk = 0, rst_n = 0;
   logic bit_stb = 0, bit_val = 0, addr_ld = 0, seq_reset = 0;
   logic commit_req = 0, wel = 1, wp_n = 1;
   logic [AW-1:0] start_addr = '0;
   logic status, wel_clr, mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0] mem_wdata;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   logic [7:0] ref_mem [DEPTH];
   logic [7:0] dut_mem [DEPTH];
   logic [7:0] m_buf [PB];
   logic [PB-1:0] m_mask = '0;
   int m_page = 0, m_ptr = 0, m_bc = 0;
   logic [7:0] m_sh = 0;

   pgw_page_writer #(.ADDR_W(AW), .PAGE_W(PW), .COMMIT_CYCLES(CC)) i_pgw_page_writer (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
      .addr_ld(addr_ld), .start_addr(start_addr), .seq_reset(seq_reset),
      .commit_req(commit_req), .wel(wel), .wp_n(wp_n), .status(status),
      .wel_clr(wel_clr), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) if (mem_we) dut_mem[mem_addr] <= mem_wdata;

   function automatic int arr_addr(int page, int idx);
      return (page << PW) | (idx & (PB - 1));
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic compare_mem(string req);
      int bad = 0;
      int first = -1;
      for (int i = 0; i < DEPTH; i++)
         if (dut_mem[i] !== ref_mem[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      check(bad == 0, req, bad, 0);
      if (bad != 0) $display("  first mismatch at %0d: %0h vs %0h", first, dut_mem[first], ref_mem[first]);
   endtask

   task automatic send_addr(int a);
      addr_ld = 1; start_addr = AW'(a);
      @(negedge clk);
      addr_ld = 0;
      m_page = a >> PW; m_ptr = a & (PB - 1); m_mask = '0; m_bc = 0;
   endtask

   task automatic send_bit(bit b);
      bit_stb = 1; bit_val = b;
      @(negedge clk);
      bit_stb = 0;
      m_sh = {m_sh[6:0], b};
      if (m_bc == 7) begin
         m_buf[m_ptr] = m_sh; m_mask[m_ptr] = 1'b1;
         m_ptr = (m_ptr + 1) % PB; m_bc = 0;
      end else m_bc++;
   endtask

   task automatic send_byte(logic [7:0] d);
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
   endtask

   task automatic idle_reset();
      seq_reset = 1;
      @(negedge clk);
      seq_reset = 0;
      m_mask = '0; m_bc = 0;
   endtask

   // act: 0 none, 1 drop wp_n mid-commit, 2 seq_reset mid-commit, 3 strobes mid-commit
   task automatic do_commit(bit w, bit p, int act);
      bit acc;
      int n;
      acc = w && p && (m_mask != '0);
      wel = w; wp_n = p; commit_req = 1;
      @(negedge clk);
      commit_req = 0;
      if (!p) check(status == 1'b1, "R4 refused while protected", status, 1);
      else if (!w) check(status == 1'b1, "R8 refused without latch", status, 1);
      else if (!acc) check(status == 1'b1, "R9 refused with nothing staged", status, 1);
      else check(status == 1'b0, "R5 status low at start", status, 0);
      if (acc) begin
         n = 0;
         while (status == 1'b0 && n < 1000) begin
            n++;
            if (n == 5) begin
               if (act == 1) wp_n = 0;
               if (act == 2) seq_reset = 1;
               if (act == 3) begin addr_ld = 1; start_addr = '0; bit_stb = 1; bit_val = 1; end
            end
            if (n == 6) begin seq_reset = 0; addr_ld = 0; bit_stb = 0; end
            @(negedge clk);
         end
         check(n == CC, "R5 busy window length", n, CC);
         check(wel_clr == 1'b1, "R7 wel_clr at completion", wel_clr, 1);
         @(negedge clk);
         check(wel_clr == 1'b0, "R7 wel_clr single cycle", wel_clr, 0);
         for (int i = 0; i < PB; i++)
            if (m_mask[i]) ref_mem[arr_addr(m_page, i)] = m_buf[i];
         m_mask = '0; m_bc = 0;
      end else begin
         repeat (3) @(negedge clk);
         check(status == 1'b1, "R4/R8/R9 stays idle", status, 1);
      end
      wp_n = 1; wel = 1;
      compare_mem(acc ? "R3 array contents" : "R4 array unchanged");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4117));
      for (int i = 0; i < DEPTH; i++) begin ref_mem[i] = 8'h00; dut_mem[i] = 8'h00; end
      repeat (3) @(negedge clk);
      check(status == 1'b1, "R11 reset status", status, 1);
      check(mem_we == 1'b0, "R11 reset mem_we", mem_we, 0);
      check(wel_clr == 1'b0, "R11 reset wel_clr", wel_clr, 0);
      rst_n = 1;
      @(negedge clk);

      // R1 R3: single byte plus trailing partial bits
      send_addr(37); send_byte(8'hA5); send_bit(1); send_bit(0); send_bit(1);
      do_commit(1, 1, 0);
      check(ref_mem[37] == 8'hA5 && dut_mem[38] == 8'h00, "R3 single byte, partial dropped", dut_mem[37], 8'hA5);

      // R2: wrap from the last position
      send_addr(arr_addr(3, 62));
      for (int i = 0; i < 4; i++) send_byte(8'(8'h10 + i));
      do_commit(1, 1, 0);
      check(dut_mem[arr_addr(3, 0)] == 8'h12, "R2 wrap to first byte", dut_mem[arr_addr(3, 0)], 8'h12);

      // R3: full page, R2 overwrite beyond a page
      send_addr(arr_addr(5, 0));
      for (int i = 0; i < PB + 2; i++) send_byte(8'(i * 3 + 1));
      do_commit(1, 1, 0);
      check(dut_mem[arr_addr(5, 1)] == 8'(PB * 3 + 4), "R2 overwrite", dut_mem[arr_addr(5, 1)], PB * 3 + 4);

      // R4: refused while protected, then accepted and protect dropped mid-commit
      send_addr(arr_addr(7, 10)); send_byte(8'h3C); send_byte(8'hC3);
      do_commit(1, 0, 0);
      do_commit(1, 1, 1);

      // R8: refused without latch
      send_addr(arr_addr(8, 20)); send_byte(8'h77);
      do_commit(0, 1, 0);
      // R6: seq_reset during commit ignored
      do_commit(1, 1, 2);
      // R9: nothing staged after commit
      do_commit(1, 1, 0);

      // R6: idle reset discards staged bytes
      send_addr(arr_addr(9, 0)); send_byte(8'hEE);
      idle_reset();
      do_commit(1, 1, 0);

      // R10: strobes during commit ignored, later load aligned
      send_addr(arr_addr(10, 5)); send_byte(8'h5A);
      do_commit(1, 1, 3);
      do_commit(1, 1, 0);
      send_addr(arr_addr(10, 6)); send_byte(8'h81);
      do_commit(1, 1, 0);
      check(dut_mem[arr_addr(10, 6)] == 8'h81, "R10 bit count untouched", dut_mem[arr_addr(10, 6)], 8'h81);

      // random mix
      for (int it = 0; it < 24; it++) begin
         int a, nb, pb;
         bit w, p;
         a  = int'($urandom % DEPTH);
         nb = 1 + int'($urandom % (PB + 8));
         pb = int'($urandom % 8);
         w  = ($urandom % 5) != 0;
         p  = ($urandom % 5) != 0;
         send_addr(a);
         for (int k = 0; k < nb; k++) send_byte(8'($urandom));
         for (int k = 0; k < pb; k++) send_bit(1'($urandom));
         do_commit(w, p, int'($urandom % 4));
         if (m_mask != '0 || m_bc != 0) idle_reset();
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule